// File: doc/BRIEF.md
# Inverter Gate-Drive Protection Controller

This block is the digital supervisory core of a three-phase half-bridge driver with one extra low-side channel, for example a brake chopper or a power-factor stage. It receives already filtered high-side and low-side commands for each leg and one auxiliary command. It also receives comparator flags for supply and current faults, a negative switch-node transient flag and an external enable level. From these it produces seven registered gate-enable outputs, a request to pull the shared open-drain fault line low, a discharge control for the fault-clear timing node, and a four-bit fault cause word for a diagnostic unit.

Each fault source has its own policy. Overcurrent and ground-fault trips are latched and clear themselves after a programmable number of cycles. A supply lockout on the logic rail lasts only as long as the condition is present. A lockout on a leg's floating supply affects only that leg's high side, and the high side is re-armed only by a fresh command edge. A qualified negative transient blocks every high side for a fixed hold-off window. Every leg inserts dead time between its two switches and refuses conflicting commands.

A three-state supervisor carries the fault policy: `FS_RUN` (gates allowed), `FS_TRIP` (latched overcurrent, timer running) and `FS_UVLO` (logic supply low). Its transitions are:
- RUN→UVLO and TRIP→UVLO on a qualified supply flag.
- RUN→TRIP on any qualified overcurrent.
- TRIP→RUN when the clear counter expires with no trip present.
- UVLO→TRIP on recovery while overcurrent causes remain, otherwise UVLO→RUN.

Each leg runs its own four-state machine: `PH_IDLE`, `PH_HIGH`, `PH_LOW` and `PH_DEAD`. A switch that turns off always passes through `PH_DEAD` for the dead-time count before the next turn-on.

Top module: `gdp_protect_core`

## Requirements
- R1: A qualified overcurrent flag forces all seven gate outputs low from the next cycle. It also drives `fault_pull_o` high and `rc_discharge_o` high, and sets its cause bit. The cause bits are: bit 0 low-side bus shunt, bit 1 ground fault, bit 2 auxiliary stage.
- R2: An overcurrent fault is latched. `fault_pull_o` falls, and cause bits 2..0 clear, exactly CLR_CYC+1 cycles after the last overcurrent flag returns low. A trip that is still present holds the timer at zero.
- R3: A qualified logic-supply undervoltage forces all seven outputs low, drives `fault_pull_o` high without discharge, and sets cause bit 3. The condition is not latched: the fault clears as soon as the flag is gone.
- R4: Undervoltage on a leg's floating supply turns off only that leg's high output. After recovery that output stays low until the leg's high command rises again.
- R5: A low level on `en_i` forces all seven outputs low while it is held, and does not drive `fault_pull_o`.
- R6: Within one leg, the high output rises exactly DEAD_CYC cycles after the low output falls, and the low output rises exactly DEAD_CYC cycles after the high output falls.
- R7: When a leg's high and low commands are both high, both of that leg's outputs are low.
- R8: A negative-transient flag present for NEG_QUAL_CYC consecutive samples holds every high output low for HOLDOFF_CYC cycles after its last qualified cycle. A shorter flag has no effect.
- R9: A fault flag is accepted only after BLANK_CYC consecutive high samples. A shorter flag has no effect on any output.
- R10: During and after reset, all gate outputs, `fault_pull_o`, `rc_discharge_o` and the cause word are zero.
- R11: With no fault present, each leg's high and low outputs follow its commands (after dead time), and the auxiliary output follows the auxiliary command one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hs_cmd_i | input | NLEG | High-side commands, one per leg |
| ls_cmd_i | input | NLEG | Low-side commands, one per leg |
| aux_cmd_i | input | 1 | Auxiliary low-side command |
| oc_dc_i | input | 1 | Low-side bus shunt overcurrent flag |
| gnd_fault_i | input | 1 | High-side bus ground-fault flag |
| oc_aux_i | input | 1 | Auxiliary stage overcurrent flag |
| vcc_uv_i | input | 1 | Logic supply undervoltage flag |
| bs_uv_i | input | NLEG | Floating-supply undervoltage flags, one per leg |
| sw_neg_i | input | 1 | Negative switch-node transient flag |
| en_i | input | 1 | External enable level, low disables |
| hs_gate_o | output | NLEG | High-side gate enables |
| ls_gate_o | output | NLEG | Low-side gate enables |
| aux_gate_o | output | 1 | Auxiliary gate enable |
| fault_pull_o | output | 1 | Pull the open-drain fault line low |
| rc_discharge_o | output | 1 | Discharge the fault-clear timing node |
| cause_o | output | 4 | Fault causes: 0 shunt, 1 ground, 2 auxiliary, 3 supply |

## Verification
The bench measures dead time to the exact cycle. A counter that is off by one, or that skips the dead state, would turn the opposite switch on one cycle early. It also times the release of a latched trip from the falling edge of the flag, where a timer that runs while the trip is still present would release the fault too soon. Flags one sample short of the blanking and transient qualification windows must leave every output untouched. After a floating-supply lockout, the bench holds the high command steady and expects the high output to stay low: a design that re-arms on the level instead of an edge would switch the gate back on.

// File: rtl/gdp_pkg.sv
package gdp_pkg;
    typedef enum logic [1:0] {
        FS_RUN  = 2'd0,
        FS_TRIP = 2'd1,
        FS_UVLO = 2'd2
    } flt_state_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2,
        PH_DEAD = 2'd3
    } leg_state_t;

    localparam int NCAUSE   = 4;
    localparam int NOC      = 3;
    localparam int CZ_SUPPLY = 3;
endpackage

// File: rtl/gdp_qual.sv
module gdp_qual #(
    parameter int N = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic qual
);
    localparam int QW = $clog2(N + 1);
    logic [QW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            qual <= 1'b0;
        end else if (!raw) begin
            cnt  <= '0;
            qual <= 1'b0;
        end else if (cnt == QW'(N - 1)) begin
            qual <= 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/gdp_holdoff.sv
module gdp_holdoff #(
    parameter int HOLD = 225
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic hold
);
    localparam int HW = $clog2(HOLD + 1);
    logic [HW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (trig)
            cnt <= HW'(HOLD);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign hold = (cnt != '0);
endmodule

// File: rtl/gdp_leg.sv
module gdp_leg
    import gdp_pkg::*;
#(
    parameter int DEAD_CYC = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic hin,
    input  logic lin,
    input  logic kill_all,
    input  logic kill_hs,
    input  logic supply_uv,
    output logic ho,
    output logic lo
);
    localparam int DW = $clog2(DEAD_CYC + 1);

    leg_state_t    st, st_n;
    logic [DW-1:0] dcnt;
    logic          hin_q, armed;
    logic          req_hi, req_lo;

    assign req_hi = hin && !lin && armed && !supply_uv && !kill_hs && !kill_all;
    assign req_lo = lin && !hin && !kill_all;

    // re-arm only on a fresh rising command edge after supply loss
    always_ff @(posedge clk) begin
        if (rst) begin
            hin_q <= 1'b0;
            armed <= 1'b1;
        end else begin
            hin_q <= hin;
            if (supply_uv)
                armed <= 1'b0;
            else if (hin && !hin_q)
                armed <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= PH_IDLE;
            dcnt <= '0;
        end else begin
            st <= st_n;
            if (st != PH_DEAD)
                dcnt <= '0;
            else if (dcnt != DW'(DEAD_CYC - 1))
                dcnt <= dcnt + 1'b1;
        end
    end

    always_comb begin
        st_n = st;
        unique case (st)
            PH_IDLE: begin
                if (req_hi)      st_n = PH_HIGH;
                else if (req_lo) st_n = PH_LOW;
            end
            PH_HIGH: if (!req_hi) st_n = PH_DEAD;
            PH_LOW:  if (!req_lo) st_n = PH_DEAD;
            PH_DEAD: begin
                if (dcnt == DW'(DEAD_CYC - 1)) begin
                    if (req_hi)      st_n = PH_HIGH;
                    else if (req_lo) st_n = PH_LOW;
                    else             st_n = PH_IDLE;
                end
            end
            default: st_n = PH_IDLE;
        endcase
    end

    always_comb begin
        ho = (st == PH_HIGH);
        lo = (st == PH_LOW);
    end
endmodule

// File: rtl/gdp_protect_core.sv
module gdp_protect_core
    import gdp_pkg::*;
#(
    parameter int NLEG         = 3,
    parameter int BLANK_CYC    = 3,
    parameter int DEAD_CYC     = 15,
    parameter int NEG_QUAL_CYC = 5,
    parameter int HOLDOFF_CYC  = 225,
    parameter int CLR_CYC      = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NLEG-1:0]   hs_cmd_i,
    input  logic [NLEG-1:0]   ls_cmd_i,
    input  logic              aux_cmd_i,
    input  logic              oc_dc_i,
    input  logic              gnd_fault_i,
    input  logic              oc_aux_i,
    input  logic              vcc_uv_i,
    input  logic [NLEG-1:0]   bs_uv_i,
    input  logic              sw_neg_i,
    input  logic              en_i,
    output logic [NLEG-1:0]   hs_gate_o,
    output logic [NLEG-1:0]   ls_gate_o,
    output logic              aux_gate_o,
    output logic              fault_pull_o,
    output logic              rc_discharge_o,
    output logic [NCAUSE-1:0] cause_o
);
    localparam int CW = $clog2(CLR_CYC + 1);

    flt_state_t       st, st_n;
    logic [CW-1:0]    clr_cnt;
    logic [NOC-1:0]   oc_raw, oc_q;
    logic             uv_q, neg_q, hs_hold, kill_all;
    logic [NLEG-1:0]  bs_q;
    logic [NCAUSE-1:0] cause_r;

    assign oc_raw = {oc_aux_i, gnd_fault_i, oc_dc_i};

    for (genvar g = 0; g < NOC; g++) begin : g_ocq
        gdp_qual #(.N(BLANK_CYC)) u_q (
            .clk(clk), .rst(rst), .raw(oc_raw[g]), .qual(oc_q[g]));
    end

    gdp_qual #(.N(BLANK_CYC)) u_uvq (
        .clk(clk), .rst(rst), .raw(vcc_uv_i), .qual(uv_q));

    gdp_qual #(.N(NEG_QUAL_CYC)) u_negq (
        .clk(clk), .rst(rst), .raw(sw_neg_i), .qual(neg_q));

    gdp_holdoff #(.HOLD(HOLDOFF_CYC)) u_hold (
        .clk(clk), .rst(rst), .trig(neg_q), .hold(hs_hold));

    // supervisor state register, clear timer and cause latch
    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= FS_RUN;
            clr_cnt <= '0;
            cause_r <= '0;
        end else begin
            st <= st_n;
            if (st_n == FS_TRIP && (st != FS_TRIP || (|oc_q)))
                clr_cnt <= '0;
            else if (st == FS_TRIP)
                clr_cnt <= clr_cnt + 1'b1;
            if (st == FS_TRIP && st_n == FS_RUN)
                cause_r[NOC-1:0] <= '0;
            else
                cause_r[NOC-1:0] <= cause_r[NOC-1:0] | oc_q;
            cause_r[CZ_SUPPLY] <= uv_q;
        end
    end

    always_comb begin
        st_n = st;
        unique case (st)
            FS_RUN: begin
                if (uv_q)        st_n = FS_UVLO;
                else if (|oc_q)  st_n = FS_TRIP;
            end
            FS_TRIP: begin
                if (uv_q)
                    st_n = FS_UVLO;
                else if (!(|oc_q) && clr_cnt == CW'(CLR_CYC - 1))
                    st_n = FS_RUN;
            end
            FS_UVLO: begin
                if (!uv_q)
                    st_n = (|cause_r[NOC-1:0]) ? FS_TRIP : FS_RUN;
            end
            default: st_n = FS_RUN;
        endcase
    end

    // supervisor outputs
    always_comb begin
        kill_all       = (st != FS_RUN) || !en_i;
        fault_pull_o   = (st != FS_RUN);
        rc_discharge_o = (st == FS_TRIP);
        cause_o        = cause_r;
    end

    for (genvar p = 0; p < NLEG; p++) begin : g_leg
        gdp_qual #(.N(BLANK_CYC)) u_bsq (
            .clk(clk), .rst(rst), .raw(bs_uv_i[p]), .qual(bs_q[p]));

        gdp_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk(clk), .rst(rst),
            .hin(hs_cmd_i[p]), .lin(ls_cmd_i[p]),
            .kill_all(kill_all), .kill_hs(hs_hold), .supply_uv(bs_q[p]),
            .ho(hs_gate_o[p]), .lo(ls_gate_o[p]));
    end

    always_ff @(posedge clk) begin
        if (rst) aux_gate_o <= 1'b0;
        else     aux_gate_o <= aux_cmd_i && !kill_all;
    end
endmodule

// File: rtl/gdp_protect_chk.sv
module gdp_protect_chk #(
    parameter int NLEG = 3
) (
    input logic            clk,
    input logic            rst,
    input logic            en_i,
    input logic [NLEG-1:0] hs_gate_o,
    input logic [NLEG-1:0] ls_gate_o,
    input logic            aux_gate_o,
    input logic            fault_pull_o,
    input logic            rc_discharge_o,
    input logic [3:0]      cause_o
);
    // R1 / R3: a pulled fault line means all gates off one cycle later
    a_r1_fault_kills_gates: assert property (@(posedge clk) disable iff (rst)
        fault_pull_o |=> (hs_gate_o == '0 && ls_gate_o == '0 && !aux_gate_o));

    // R5: enable low kills all gates on the next cycle
    a_r5_enable_kills_gates: assert property (@(posedge clk) disable iff (rst)
        !en_i |=> (hs_gate_o == '0 && ls_gate_o == '0 && !aux_gate_o));

    // R7: never both switches of one leg on
    a_r7_no_shoot_through: assert property (@(posedge clk) disable iff (rst)
        (hs_gate_o & ls_gate_o) == '0);

    // R1: a pulled fault line always carries a recorded cause
    a_r1_fault_has_cause: assert property (@(posedge clk) disable iff (rst)
        fault_pull_o |-> (cause_o != 4'b0000));

    // R2 / R3: discharge only for a latched overcurrent, never for supply loss alone
    a_r2_discharge_has_oc_cause: assert property (@(posedge clk) disable iff (rst)
        rc_discharge_o |-> (cause_o[2:0] != 3'b000 && fault_pull_o));
endmodule

bind gdp_protect_core gdp_protect_chk #(.NLEG(NLEG)) u_chk (
    .clk(clk), .rst(rst), .en_i(en_i),
    .hs_gate_o(hs_gate_o), .ls_gate_o(ls_gate_o), .aux_gate_o(aux_gate_o),
    .fault_pull_o(fault_pull_o), .rc_discharge_o(rc_discharge_o),
    .cause_o(cause_o));

// File: tb/tb_gdp_protect_core.sv
`timescale 1ns/1ps
module tb_gdp_protect_core;
    localparam int DEAD = 15;
    localparam int HOLD = 225;
    localparam int CLR  = 1000;

    logic       clk = 1'b0;
    logic       rst;
    logic [2:0] hin, lin, bsuv;
    logic       aux, dc, gf, ax, uv, nvs, en;
    logic [2:0] ho, lo;
    logic       auxo, flt, rcd;
    logic [3:0] cause;
    int         n_chk = 0, n_bad = 0;
    bit         done  = 1'b0;

    always #10 clk = ~clk;

    gdp_protect_core dut (
        .clk(clk), .rst(rst), .hs_cmd_i(hin), .ls_cmd_i(lin), .aux_cmd_i(aux),
        .oc_dc_i(dc), .gnd_fault_i(gf), .oc_aux_i(ax), .vcc_uv_i(uv),
        .bs_uv_i(bsuv), .sw_neg_i(nvs), .en_i(en),
        .hs_gate_o(ho), .ls_gate_o(lo), .aux_gate_o(auxo),
        .fault_pull_o(flt), .rc_discharge_o(rcd), .cause_o(cause));

    // [39:37] hin [36:34] lin [33] aux [32:30] {ax,gf,dc} [29] uv [28:26] bsuv
    // [25] nvs [24] en [23:13] wait [12:0] {ho,lo,auxo,flt,rcd,cause}
    localparam logic [39:0] VEC [16] = '{
        {3'b001,3'b010,1'b1,3'b000,1'b0,3'b000,1'b0,1'b1,11'd40,  3'b001,3'b010,1'b1,1'b0,1'b0,4'b0000},
        {3'b100,3'b011,1'b0,3'b000,1'b0,3'b000,1'b0,1'b1,11'd40,  3'b100,3'b011,1'b0,1'b0,1'b0,4'b0000},
        {3'b101,3'b001,1'b0,3'b000,1'b0,3'b000,1'b0,1'b1,11'd40,  3'b100,3'b000,1'b0,1'b0,1'b0,4'b0000},
        {3'b100,3'b011,1'b1,3'b000,1'b0,3'b000,1'b0,1'b0,11'd40,  3'b000,3'b000,1'b0,1'b0,1'b0,4'b0000},
        {3'b100,3'b011,1'b1,3'b000,1'b0,3'b000,1'b0,1'b1,11'd40,  3'b100,3'b011,1'b1,1'b0,1'b0,4'b0000},
        {3'b100,3'b011,1'b1,3'b001,1'b0,3'b000,1'b0,1'b1,11'd40,  3'b000,3'b000,1'b0,1'b1,1'b1,4'b0001},
        {3'b100,3'b011,1'b1,3'b000,1'b0,3'b000,1'b0,1'b1,11'd1040,3'b100,3'b011,1'b1,1'b0,1'b0,4'b0000},
        {3'b100,3'b011,1'b1,3'b010,1'b0,3'b000,1'b0,1'b1,11'd40,  3'b000,3'b000,1'b0,1'b1,1'b1,4'b0010},
        {3'b100,3'b011,1'b1,3'b100,1'b0,3'b000,1'b0,1'b1,11'd40,  3'b000,3'b000,1'b0,1'b1,1'b1,4'b0110},
        {3'b100,3'b011,1'b1,3'b000,1'b0,3'b000,1'b0,1'b1,11'd1040,3'b100,3'b011,1'b1,1'b0,1'b0,4'b0000},
        {3'b100,3'b011,1'b1,3'b000,1'b1,3'b000,1'b0,1'b1,11'd40,  3'b000,3'b000,1'b0,1'b1,1'b0,4'b1000},
        {3'b100,3'b011,1'b1,3'b000,1'b0,3'b000,1'b0,1'b1,11'd40,  3'b100,3'b011,1'b1,1'b0,1'b0,4'b0000},
        {3'b100,3'b011,1'b1,3'b000,1'b0,3'b100,1'b0,1'b1,11'd40,  3'b000,3'b011,1'b1,1'b0,1'b0,4'b0000},
        {3'b100,3'b011,1'b1,3'b000,1'b0,3'b000,1'b0,1'b1,11'd40,  3'b000,3'b011,1'b1,1'b0,1'b0,4'b0000},
        {3'b000,3'b011,1'b1,3'b000,1'b0,3'b000,1'b0,1'b1,11'd40,  3'b000,3'b011,1'b1,1'b0,1'b0,4'b0000},
        {3'b100,3'b011,1'b1,3'b000,1'b0,3'b000,1'b0,1'b1,11'd40,  3'b100,3'b011,1'b1,1'b0,1'b0,4'b0000}
    };
    // requirement per vector
    localparam string VTAG [16] = '{"R11","R11","R7","R5","R5","R1","R2","R1","R1",
                                    "R2","R3","R3","R4","R4","R4","R4"};

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] obs();
        return {3'b000, ho, lo, auxo, flt, rcd, cause};
    endfunction

    initial begin
        rst = 1'b1; hin = '0; lin = '0; bsuv = '0;
        aux = 0; dc = 0; gf = 0; ax = 0; uv = 0; nvs = 0; en = 1;
        step(3);
        check("R10 reset", obs(), 16'h0000);
        rst = 1'b0;
        step(1);
        check("R10 after reset", obs(), 16'h0000);

        for (int i = 0; i < 16; i++) begin
            {hin, lin, aux, ax, gf, dc, uv, bsuv, nvs, en} = VEC[i][39:24];
            step(int'(VEC[i][23:13]));
            check(VTAG[i], obs(), {3'b000, VEC[i][12:0]});
        end

        // R6: leg 0 from low to high, exact dead time
        hin = 3'b101; lin = 3'b010;
        step(1);
        check("R6 low off", {14'd0, ho[0], lo[0]}, 16'h0000);
        step(DEAD - 1);
        check("R6 high still off", {15'd0, ho[0]}, 16'h0000);
        step(1);
        check("R6 high on", {15'd0, ho[0]}, 16'h0001);
        // R6: back to low side
        hin = 3'b100; lin = 3'b011;
        step(DEAD);
        check("R6 low still off", {14'd0, ho[0], lo[0]}, 16'h0000);
        step(1);
        check("R6 low on", {15'd0, lo[0]}, 16'h0001);

        // R9: shunt flag one sample short of blanking is ignored
        dc = 1'b1; step(2); dc = 1'b0;
        step(10);
        check("R9 glitch ignored", obs(), {3'b000, 3'b100, 3'b011, 1'b1, 1'b0, 1'b0, 4'b0000});

        // R2: exact release time after the flag falls
        dc = 1'b1; step(5); dc = 1'b0;
        step(CLR);
        check("R2 still latched", {15'd0, flt}, 16'h0001);
        step(1);
        check("R2 released", {11'd0, flt, cause}, 16'h0000);
        step(40);

        // R8: short transient ignored
        nvs = 1'b1; step(4); nvs = 1'b0;
        step(10);
        check("R8 short transient ignored", {13'd0, ho}, 16'h0004);
        // R8: qualified transient holds high sides off
        nvs = 1'b1; step(8); nvs = 1'b0;
        check("R8 hold active", {10'd0, ho, lo}, {10'd0, 3'b000, 3'b011});
        step(HOLD);
        check("R8 hold to end", {13'd0, ho}, 16'h0000);
        step(6);
        check("R8 hold released", {13'd0, ho}, 16'h0004);

        // R10: reset in operation
        rst = 1'b1; step(2);
        check("R10 mid reset", obs(), 16'h0000);
        rst = 1'b0;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule